// File: doc/BRIEF.md
# Buffered-Update PWM Channel

A single pulse-width modulation channel. A period counter steps through the values 0 to period−1 and advances once every 2^n clocks, where n comes from a prescaler field in the mode register. The duty register sets how many counts of each period stay at the inactive level. The rest of the period is at the active level. A polarity bit selects whether the active level is high or low.

While the channel runs, software changes duty or period through one shared update register. A written value waits until the current period ends and is then copied into the duty or period register. A bit in the mode register selects which of the two it goes to. This keeps each period glitch-free.

Period and duty can be written directly only while the channel is stopped. Enable comes from outside the block. When enable is dropped, the channel completes the period it is in, then stops, drives the inactive level and discards any pending update. A one-cycle end-of-period strobe is exported.

Top module: `pwm_buffered_channel`

## Requirements
- R1: After reset, `running`, `period_end` and `pwm_out` are 0. The mode fields reset to prescaler 0, polarity 0 and update target duty.
- R2: The counter advances once every 2^n clocks. n is `mode_wdata[3:0]` as last written. Values of n above 10 behave as 10.
- R3: The counter runs from 0 to period−1. `period_end` is high for exactly one clock, on the last clock of the last count. Successive strobes are period·2^n clocks apart.
- R4: The output is inactive while the count is below duty and active from there to the end of the period, giving (period−duty)·2^n active clocks. A duty of 0 is active for the whole period. A duty at or above the period is never active.
- R5: Polarity is `mode_wdata[9]`. With 0 the active level is 1 and the inactive level is 0. With 1 both levels are inverted.
- R6: A value written through `upd_we` is held until the end of the current period and then copied into duty when `mode_wdata[10]` was written 0, or into period when it was written 1. The period in which the write happens is unaffected.
- R7: `period_we` and `duty_we` are ignored while `running` is 1.
- R8: While stopped, a high `run_req` starts the channel at count 0. When `run_req` is low at an end of period, the channel completes that period and then drops `running`. Its output is held at the inactive level while stopped.
- R9: A pending update is discarded, not applied, when the channel stops. Updates written while the channel is stopped are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Channel enable request |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 11 | Mode: [3:0] prescaler exponent, [9] polarity, [10] update target |
| period_we | input | 1 | Direct period write strobe (stopped only) |
| period_wdata | input | W | Period value in counts |
| duty_we | input | 1 | Direct duty write strobe (stopped only) |
| duty_wdata | input | W | Inactive counts per period |
| upd_we | input | 1 | Update register write strobe |
| upd_wdata | input | W | Value transferred at the next period end |
| pwm_out | output | 1 | Waveform |
| period_end | output | 1 | One-clock strobe on the last clock of each period |
| running | output | 1 | Channel is active |

## Verification
On every cycle the assertions check four things. The end-of-period strobe appears only while running. The channel stops only on the clock after a strobe. The output holds the inactive level while stopped. Duty and period change during a run only at a period boundary.

Period length, active time against duty, polarity, prescaler scaling and its clamp can only be shown by the bench's scenarios. The same holds for the one-period delay of an update and for dropped updates on stop. The bench measures these as clock counts between strobes.

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel #(
  parameter int W = 16,
  parameter int PRE_MAX = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_req,
  input  logic         mode_we,
  input  logic [10:0]  mode_wdata,
  input  logic         period_we,
  input  logic [W-1:0] period_wdata,
  input  logic         duty_we,
  input  logic [W-1:0] duty_wdata,
  input  logic         upd_we,
  input  logic [W-1:0] upd_wdata,
  output logic         pwm_out,
  output logic         period_end,
  output logic         running
);

  localparam int PW = PRE_MAX;

  logic [3:0]    psel_q;
  logic          pol_q, tgt_q;
  logic [W-1:0]  per_q, duty_q, pend_q, cnt_q;
  logic          pend_v, run_q;
  logic [PW-1:0] pre_q;
  logic [3:0]    psel_eff;
  logic [PW-1:0] pre_lim;
  logic [W-1:0]  last;
  logic          tick, eop;
  logic          unused_mode;

  assign unused_mode = ^mode_wdata[8:4];
  assign psel_eff = (psel_q > 4'(PRE_MAX)) ? 4'(PRE_MAX) : psel_q;
  assign pre_lim  = ~({PW{1'b1}} << psel_eff);
  assign tick     = run_q && (pre_q >= pre_lim);
  assign last     = (per_q == '0) ? '0 : per_q - 1'b1;
  assign eop      = tick && (cnt_q >= last);

  assign period_end = eop;
  assign running    = run_q;
  assign pwm_out    = pol_q ^ (run_q && (cnt_q >= duty_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel_q <= '0;
      pol_q  <= 1'b0;
      tgt_q  <= 1'b0;
    end else if (mode_we) begin
      psel_q <= mode_wdata[3:0];
      pol_q  <= mode_wdata[9];
      tgt_q  <= mode_wdata[10];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      pend_v <= 1'b0;
      if (run_req)   run_q  <= 1'b1;
      if (period_we) per_q  <= period_wdata;
      if (duty_we)   duty_q <= duty_wdata;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= eop ? '0 : cnt_q + 1'b1;
      if (eop && !run_req) run_q <= 1'b0;
      if (eop && pend_v && run_req) begin
        if (tgt_q) per_q  <= pend_q;
        else       duty_q <= pend_q;
      end
      if (upd_we) begin
        pend_v <= 1'b1;
        pend_q <= upd_wdata;
      end else if (eop) begin
        pend_v <= 1'b0;
      end
    end
  end

  // R3
  eop_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> running);

  // R8
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(period_end));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == pol_q));

  // R6
  duty_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(duty_q) && $past(running)) |-> $past(period_end));

  // R6
  period_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_q) && $past(running)) |-> $past(period_end));

endmodule

// File: tb/pwm_buffered_channel_test.sv
module pwm_buffered_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_req = 1'b0;
  logic        mode_we = 1'b0, period_we = 1'b0, duty_we = 1'b0, upd_we = 1'b0;
  logic [10:0] mode_wdata = '0;
  logic [15:0] period_wdata = '0, duty_wdata = '0, upd_wdata = '0;
  logic        pwm_out, period_end, running;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, act = 0, seg_len = 0, seg_act = 0;
  logic pol_b = 1'b0;
  event seg_done;

  always #4 clk = ~clk;

  pwm_buffered_channel uut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .upd_we(upd_we), .upd_wdata(upd_wdata),
    .pwm_out(pwm_out), .period_end(period_end), .running(running));

  always @(negedge clk) begin
    if (rst_n) begin
      if (period_end) begin
        seg_len = cyc + 1;
        seg_act = act + ((pwm_out != pol_b) ? 1 : 0);
        cyc = 0;
        act = 0;
        ->seg_done;
      end else begin
        cyc = cyc + 1;
        act = act + ((pwm_out != pol_b) ? 1 : 0);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_len(input int per, input int ps);
    int n = (ps > 10) ? 10 : ps;
    return per << n;
  endfunction

  function automatic int exp_act(input int per, input int duty, input int ps);
    int n = (ps > 10) ? 10 : ps;
    return (duty >= per) ? 0 : ((per - duty) << n);
  endfunction

  task automatic wr(input int kind, input logic [15:0] v);
    case (kind)
      0: begin mode_wdata = v[10:0]; mode_we = 1'b1; end
      1: begin period_wdata = v; period_we = 1'b1; end
      2: begin duty_wdata = v; duty_we = 1'b1; end
      default: begin upd_wdata = v; upd_we = 1'b1; end
    endcase
    @(posedge clk);
    #1;
    mode_we = 1'b0; period_we = 1'b0; duty_we = 1'b0; upd_we = 1'b0;
  endtask

  function automatic logic [15:0] mode_val(input int ps, input logic pol, input logic tgt);
    return {5'd0, tgt, pol, 5'd0, 4'(ps)};
  endfunction

  task automatic stop_ch();
    @(negedge clk);
    run_req = 1'b0;
    while (running) @(negedge clk);
  endtask

  task automatic start_cfg(input int per, input int duty, input int ps,
                           input logic pol, input logic tgt);
    stop_ch();
    wr(0, mode_val(ps, pol, tgt));
    wr(1, 16'(per));
    wr(2, 16'(duty));
    pol_b = pol;
    @(negedge clk);
    run_req = 1'b1;
    @(seg_done);
  endtask

  task automatic measure(input string req, input int per, input int duty, input int ps);
    @(seg_done);
    chk({req, " period length"}, seg_len, exp_len(per, ps));
    chk({req, " active time"}, seg_act, exp_act(per, duty, ps));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 running", int'(running), 0);
    chk("R1 period_end", int'(period_end), 0);
    chk("R1 pwm_out", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_out after release", int'(pwm_out), 0);
    // R1 default mode: prescaler 0, polarity 0
    wr(1, 16'd10);
    wr(2, 16'd4);
    @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    chk("R8 start", int'(running), 1);
    @(seg_done);
    measure("R1 R4 default", 10, 4, 0);

    // R2 prescaler scaling, R3 strobe width
    start_cfg(10, 4, 2, 1'b0, 1'b0);
    measure("R2", 10, 4, 2);
    @(negedge clk);
    chk("R3 strobe one clock", int'(period_end), 0);

    // R2 clamp above 10
    start_cfg(2, 1, 15, 1'b0, 1'b0);
    measure("R2 clamp", 2, 1, 15);

    // R4 corners
    start_cfg(7, 0, 1, 1'b0, 1'b0);
    measure("R4 duty zero", 7, 0, 1);
    start_cfg(7, 10, 1, 1'b0, 1'b0);
    measure("R4 duty above period", 7, 10, 1);

    // R5 inverted polarity
    start_cfg(9, 3, 0, 1'b1, 1'b0);
    measure("R5", 9, 3, 0);
    stop_ch();
    @(negedge clk);
    chk("R5 idle level inverted", int'(pwm_out), 1);

    // random configurations
    for (int i = 0; i < 8; i++) begin
      int per = $urandom_range(24, 2);
      int duty = $urandom_range(per + 2, 0);
      int ps = $urandom_range(3, 0);
      logic pol = 1'($urandom_range(1, 0));
      start_cfg(per, duty, ps, pol, 1'b0);
      measure("R3 R4 R5 random", per, duty, ps);
      measure("R3 R4 R5 random", per, duty, ps);
    end

    // R6 duty update held one period
    start_cfg(12, 3, 1, 1'b0, 1'b0);
    @(seg_done);
    wr(3, 16'd8);
    measure("R6 duty old period", 12, 3, 1);
    measure("R6 duty new period", 12, 8, 1);

    // R6 period update
    start_cfg(12, 3, 0, 1'b0, 1'b1);
    @(seg_done);
    wr(3, 16'd20);
    measure("R6 period old", 12, 3, 0);
    measure("R6 period new", 20, 3, 0);

    // R7 direct writes ignored while running
    start_cfg(10, 2, 0, 1'b0, 1'b0);
    @(seg_done);
    wr(2, 16'd7);
    wr(1, 16'd5);
    measure("R7", 10, 2, 0);
    measure("R7", 10, 2, 0);

    // R8 completes period then stops
    start_cfg(10, 5, 1, 1'b0, 1'b0);
    @(seg_done);
    repeat (3) @(negedge clk);
    run_req = 1'b0;
    chk("R8 still running", int'(running), 1);
    @(seg_done);
    chk("R8 final period full", seg_len, exp_len(10, 1));
    chk("R8 running at last clock", int'(running), 1);
    @(negedge clk);
    chk("R8 stopped", int'(running), 0);
    chk("R8 idle level", int'(pwm_out), 0);
    repeat (5) @(negedge clk);
    chk("R8 stays stopped", int'(running), 0);

    // R9 pending dropped on stop, stopped writes dropped
    start_cfg(10, 2, 0, 1'b0, 1'b0);
    @(seg_done);
    wr(3, 16'd6);
    @(negedge clk);
    run_req = 1'b0;
    while (running) @(negedge clk);
    wr(3, 16'd9);
    @(negedge clk);
    run_req = 1'b1;
    @(seg_done);
    measure("R9", 10, 2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule